// File: doc/BRIEF.md
# MDIO Management Slave

This block is the device-side end of a two-wire serial management link. The management master supplies a clock (MDC) and a shared data line (MDIO). The block samples MDIO on every rising MDC edge and looks for a start sequence. It then decodes a read or write frame. When the frame carries this device's address, the block reads or writes one entry of a small internal register store. For a read it drives the line back to the master during the turnaround and data fields. At all other times its output enable stays low, so the line is left to the master and the pull-up.

A frame arrives in this order: an idle/preamble run of ones, a two-bit start code `01`, a two-bit operation code, a 5-bit device address and a 5-bit register address. A two-bit turnaround follows, then 16 data bits. Every field is sent most significant bit first.

The block does not take its own device address from fixed pins. It keeps it in a field of register 16, which is loaded from a strap input at reset and can be rewritten over the link. A mode input lets the block accept frames that skip the long preamble. A read-only status register reports whether that mode is on. Each completed write is also shown on a one-cycle strobe with its register number and value, so that logic around the block can follow the changes.

Top module: `mdio_slave`

## Requirements
- R1: While reset is asserted and after it is released, `mdio_oe` and `wr_stb` are low. Every register reads 0, except that register 16 reads with `strap_addr` placed in bits 10:6.
- R2: With `pre_sup_en` low, the block starts a frame only when the start code `01` follows at least 32 consecutive ones sampled while hunting. If the run has 31 ones or fewer, the block drives nothing and writes nothing.
- R3: With `pre_sup_en` high, a start code that follows a run of at least one 1 is accepted. Register 1 bit 6 reads as the current value of `pre_sup_en`.
- R4: An operation code of `10` is a read and `01` is a write. The codes `00` and `11` abandon the frame: the block never drives MDIO for it and changes no register.
- R5: After the operation code, the block takes 5 bits of device address and then 5 bits of register address, each most significant bit first.
- R6: When the device address in a frame differs from register 16 bits 10:6, the block ignores the frame. It does not drive MDIO and does not write.
- R7: On a matched read, `mdio_oe` stays low for the first turnaround bit period. It then goes high with `mdio_o` low for the second turnaround bit period.
- R8: On a matched read, the block presents the 16 register bits most significant bit first, one per MDC period, each changing after a rising edge. `mdio_oe` falls after the rising edge that ends the last data bit.
- R9: On a matched write, the block ignores the two turnaround bits and samples 16 data bits most significant bit first. It then raises `wr_stb` for exactly one cycle after the edge that samples the last data bit, with `wr_reg` and `wr_val` holding the target register and value. The block never drives MDIO during a write.
- R10: A write to register 16 changes the device address for the frames that follow. After that, the old address is ignored and the new one is answered.
- R11: Register 1 is read-only. A write to it still pulses `wr_stb`, but its read value does not change.
- R12: If the second start-code bit is 0 (start code `00`), the block returns to hunting. It drives nothing and writes nothing for the rest of that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| mdc | input | 1 | Management clock; all sampling is on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_addr | input | 5 | Device address loaded into register 16 bits 10:6 at reset |
| pre_sup_en | input | 1 | Accept frames with a shortened preamble when high |
| mdio_i | input | 1 | Sampled value of the MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO when enabled |
| mdio_oe | output | 1 | Output enable for the MDIO pad driver |
| wr_stb | output | 1 | One-cycle pulse when a write frame completes |
| wr_reg | output | 5 | Register number of the completed write |
| wr_val | output | 16 | Data value of the completed write |

## Verification
The embedded assertions check on every cycle that the driver is enabled only inside a read frame's turnaround-and-data window. They also check that the enable rises with a low level and falls only as the sequencer returns to hunting, and that the write strobe never lasts two cycles. They confirm that the preamble counter holds a nonzero count only after sampling ones, and that the device address moves only on a write to its register. Only the bench scenarios can show the frame-level results: which preamble lengths and start codes are accepted, the bit order of address and data, that frames with a mismatched address or an invalid code leave the registers untouched, and how rewriting the address register or switching preamble suppression changes later frames.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int MDIO_DW      = 16;
    localparam int MDIO_AW      = 5;
    localparam int MDIO_PRE_LEN = 32;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SFD,
        ST_OP,
        ST_ADR,
        ST_TA1,
        ST_TA2,
        ST_DAT
    } seq_st_e;

endpackage

// File: rtl/mdio_pre_det.sv
module mdio_pre_det
    import mdio_pkg::*;
#(
    parameter int PRE_LEN = MDIO_PRE_LEN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_i,
    input  logic hunt,
    input  logic sup_en,
    output logic start
);
    localparam int CW = $clog2(PRE_LEN + 1);
    localparam logic [CW-1:0] FULL = CW'(PRE_LEN);

    logic [CW-1:0] cnt_q, cnt_d;

    // Count ones while hunting; a zero either starts a frame or clears the run.
    always_comb begin
        cnt_d = cnt_q;
        start = 1'b0;
        if (!hunt) begin
            cnt_d = '0;
        end else if (bit_i) begin
            cnt_d = (cnt_q == FULL) ? cnt_q : cnt_q + 1'b1;
        end else begin
            start = (cnt_q == FULL) || (sup_en && (cnt_q != '0));
            cnt_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_RUN_FROM_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != '0) |-> $past(bit_i)); // R2
    AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q <= FULL)); // R2

endmodule

// File: rtl/mdio_frame_seq.sv
module mdio_frame_seq
    import mdio_pkg::*;
#(
    parameter int DW = MDIO_DW,
    parameter int AW = MDIO_AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bit_i,
    input  logic          start,
    input  logic [AW-1:0] phy_addr,
    input  logic [DW-1:0] rd_data,
    output logic          hunt,
    output logic [AW-1:0] rd_addr,
    output logic          mdio_o,
    output logic          mdio_oe,
    output logic          wr_stb,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int CW = $clog2((DW > 2 * AW) ? DW : 2 * AW);
    localparam logic [CW-1:0] OP_LAST  = CW'(1);
    localparam logic [CW-1:0] ADR_LAST = CW'(2 * AW - 1);
    localparam logic [CW-1:0] DAT_LAST = CW'(DW - 1);

    typedef struct packed {
        seq_st_e       st;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic          rd;
        logic [AW-1:0] reg_a;
        logic          oe;
        logic          o;
        logic          wstb;
        logic [AW-1:0] wa;
        logic [DW-1:0] wd;
    } seq_t;

    localparam seq_t SEQ_RST = '{st: ST_HUNT, default: '0};

    seq_t q, d;
    logic [AW-1:0] phy_rx;
    logic [DW-1:0] sh_in;

    // Device address sits above the four register bits already received.
    assign phy_rx  = q.sh[2*AW-2 -: AW];
    assign rd_addr = {q.sh[AW-2:0], bit_i};
    assign sh_in   = {q.sh[DW-2:0], bit_i};
    assign hunt    = (q.st == ST_HUNT);

    always_comb begin
        d      = q;
        d.wstb = 1'b0;
        unique case (q.st)
            ST_HUNT: begin
                if (start) d.st = ST_SFD;
            end
            ST_SFD: begin
                d.cnt = '0;
                d.st  = bit_i ? ST_OP : ST_HUNT;
            end
            ST_OP: begin
                d.sh = sh_in;
                if (q.cnt == OP_LAST) begin
                    d.cnt = '0;
                    case ({q.sh[0], bit_i})
                        OP_READ:  begin d.rd = 1'b1; d.st = ST_ADR; end
                        OP_WRITE: begin d.rd = 1'b0; d.st = ST_ADR; end
                        default:  d.st = ST_HUNT;
                    endcase
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_ADR: begin
                d.sh = sh_in;
                if (q.cnt == ADR_LAST) begin
                    d.cnt = '0;
                    if (phy_rx == phy_addr) begin
                        d.st    = ST_TA1;
                        d.reg_a = rd_addr;
                        if (q.rd) d.sh = rd_data;
                    end else begin
                        d.st = ST_HUNT;
                    end
                end else begin
                    d.cnt = q.cnt + 1'b1;
                end
            end
            ST_TA1: begin
                d.st = ST_TA2;
                if (q.rd) begin
                    d.oe = 1'b1;
                    d.o  = 1'b0;
                end
            end
            ST_TA2: begin
                d.st  = ST_DAT;
                d.cnt = '0;
                if (q.rd) begin
                    d.o  = q.sh[DW-1];
                    d.sh = {q.sh[DW-2:0], 1'b0};
                end
            end
            ST_DAT: begin
                if (q.rd) begin
                    if (q.cnt == DAT_LAST) begin
                        d.oe = 1'b0;
                        d.o  = 1'b0;
                        d.st = ST_HUNT;
                    end else begin
                        d.o   = q.sh[DW-1];
                        d.sh  = {q.sh[DW-2:0], 1'b0};
                        d.cnt = q.cnt + 1'b1;
                    end
                end else begin
                    d.sh = sh_in;
                    if (q.cnt == DAT_LAST) begin
                        d.wstb = 1'b1;
                        d.wa   = q.reg_a;
                        d.wd   = sh_in;
                        d.st   = ST_HUNT;
                    end else begin
                        d.cnt = q.cnt + 1'b1;
                    end
                end
            end
            default: d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SEQ_RST;
        else        q <= d;
    end

    assign mdio_o  = q.o;
    assign mdio_oe = q.oe;
    assign wr_stb  = q.wstb;
    assign wr_addr = q.wa;
    assign wr_data = q.wd;

    AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> q.rd); // R9
    AST_TA_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o); // R7
    AST_DRIVE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        q.oe |-> (q.st == ST_TA2 || q.st == ST_DAT)); // R8
    AST_RELEASE_TO_HUNT: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mdio_oe) |-> (q.st == ST_HUNT)); // R8
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.wstb |=> !q.wstb); // R9

endmodule

// File: rtl/mdio_reg_store.sv
module mdio_reg_store
    import mdio_pkg::*;
#(
    parameter int DW       = MDIO_DW,
    parameter int AW       = MDIO_AW,
    parameter int PAW      = 5,
    parameter int RO_REG   = 1,
    parameter int SUP_BIT  = 6,
    parameter int ADDR_REG = 16,
    parameter int ADDR_LSB = 6
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [PAW-1:0] strap_addr,
    input  logic           sup_en,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [DW-1:0]  wr_data,
    input  logic [AW-1:0]  rd_addr,
    output logic [DW-1:0]  rd_data,
    output logic [PAW-1:0] phy_addr
);
    localparam int NREGS = 1 << AW;

    logic [DW-1:0] val_vec [NREGS];
    logic [DW-1:0] sts_word;

    assign sts_word = DW'(sup_en) << SUP_BIT;

    for (genvar i = 0; i < NREGS; i++) begin : g_reg
        logic [DW-1:0] val_q, val_d, rst_val;
        logic          we;

        if (i == ADDR_REG) begin : g_addr_rst
            assign rst_val = DW'(strap_addr) << ADDR_LSB;
        end else begin : g_zero_rst
            assign rst_val = '0;
        end

        if (i == RO_REG) begin : g_ro
            assign we = 1'b0;
        end else begin : g_rw
            assign we = wr_en && (wr_addr == AW'(i));
        end

        always_comb begin
            val_d = we ? wr_data : val_q;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) val_q <= rst_val;
            else        val_q <= val_d;
        end

        assign val_vec[i] = val_q;
    end

    assign rd_data  = (rd_addr == AW'(RO_REG)) ? sts_word : val_vec[rd_addr];
    assign phy_addr = val_vec[ADDR_REG][ADDR_LSB +: PAW];

    AST_ADDR_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == AW'(ADDR_REG)) |=> $stable(phy_addr)); // R10

endmodule

// File: rtl/mdio_slave.sv
module mdio_slave
    import mdio_pkg::*;
#(
    parameter int DW      = MDIO_DW,
    parameter int AW      = MDIO_AW,
    parameter int PRE_LEN = MDIO_PRE_LEN
) (
    input  logic          mdc,
    input  logic          rst_n,
    input  logic [4:0]    strap_addr,
    input  logic          pre_sup_en,
    input  logic          mdio_i,
    output logic          mdio_o,
    output logic          mdio_oe,
    output logic          wr_stb,
    output logic [AW-1:0] wr_reg,
    output logic [DW-1:0] wr_val
);
    localparam int PAW = 5;

    logic           hunt, start;
    logic [AW-1:0]  rd_addr;
    logic [DW-1:0]  rd_data;
    logic [PAW-1:0] phy_addr;

    mdio_pre_det #(.PRE_LEN(PRE_LEN)) u_pre (
        .clk    (mdc),
        .rst_n  (rst_n),
        .bit_i  (mdio_i),
        .hunt   (hunt),
        .sup_en (pre_sup_en),
        .start  (start)
    );

    mdio_frame_seq #(.DW(DW), .AW(AW)) u_seq (
        .clk      (mdc),
        .rst_n    (rst_n),
        .bit_i    (mdio_i),
        .start    (start),
        .phy_addr (phy_addr),
        .rd_data  (rd_data),
        .hunt     (hunt),
        .rd_addr  (rd_addr),
        .mdio_o   (mdio_o),
        .mdio_oe  (mdio_oe),
        .wr_stb   (wr_stb),
        .wr_addr  (wr_reg),
        .wr_data  (wr_val)
    );

    mdio_reg_store #(.DW(DW), .AW(AW), .PAW(PAW)) u_regs (
        .clk        (mdc),
        .rst_n      (rst_n),
        .strap_addr (strap_addr),
        .sup_en     (pre_sup_en),
        .wr_en      (wr_stb),
        .wr_addr    (wr_reg),
        .wr_data    (wr_val),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .phy_addr   (phy_addr)
    );

endmodule

// File: tb/sim_mdio_slave.sv
module sim_mdio_slave;

    logic        mdc = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  strap_addr = 5'h0B;
    logic        pre_sup_en = 1'b0;
    logic        mdio_i = 1'b1;
    logic        mdio_o, mdio_oe, wr_stb;
    logic [4:0]  wr_reg;
    logic [15:0] wr_val;

    int checks = 0;
    int errors = 0;

    always #5 mdc = ~mdc;

    mdio_slave u0 (
        .mdc(mdc), .rst_n(rst_n), .strap_addr(strap_addr), .pre_sup_en(pre_sup_en),
        .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
        .wr_stb(wr_stb), .wr_reg(wr_reg), .wr_val(wr_val)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tx(input logic b);
        @(negedge mdc);
        mdio_i = b;
        @(posedge mdc);
    endtask

    // Two zeros clear any ones run and any half-started frame.
    task automatic hdr(input int npre, input logic [1:0] sfd, input logic [1:0] op,
                       input logic [4:0] pa, input logic [4:0] ra);
        tx(1'b0); tx(1'b0);
        repeat (npre) tx(1'b1);
        tx(sfd[1]); tx(sfd[0]);
        tx(op[1]);  tx(op[0]);
        for (int i = 4; i >= 0; i--) tx(pa[i]);
        for (int i = 4; i >= 0; i--) tx(ra[i]);
    endtask

    task automatic rd_frame(input int npre, input logic [1:0] sfd, input logic [1:0] op,
                            input logic [4:0] pa, input logic [4:0] ra,
                            output logic [18:0] oe_v, output logic [18:0] o_v);
        hdr(npre, sfd, op, pa, ra);
        for (int k = 0; k < 19; k++) begin
            @(negedge mdc);
            oe_v[k] = mdio_oe;
            o_v[k]  = mdio_o;
            mdio_i  = 1'b1;
            @(posedge mdc);
        end
    endtask

    task automatic rd_expect(input int npre, input logic [4:0] pa, input logic [4:0] ra,
                             input logic [15:0] exp, input string tag);
        logic [18:0] oe_v, o_v;
        logic [15:0] data;
        rd_frame(npre, 2'b01, 2'b10, pa, ra, oe_v, o_v);
        for (int k = 0; k < 16; k++) data[15-k] = o_v[k+2];
        chk(oe_v[1:0] == 2'b10 && !o_v[1], {tag, " R7 turnaround"},
            {29'd0, oe_v[1:0], o_v[1]}, 32'b100);
        chk(oe_v == 19'h3FFFE, {tag, " R8 drive window"}, 32'(oe_v), 32'h3FFFE);
        chk(data == exp, {tag, " R8 read data"}, 32'(data), 32'(exp));
    endtask

    task automatic rd_none(input int npre, input logic [1:0] sfd, input logic [1:0] op,
                           input logic [4:0] pa, input logic [4:0] ra, input string tag);
        logic [18:0] oe_v, o_v;
        rd_frame(npre, sfd, op, pa, ra, oe_v, o_v);
        chk(oe_v == '0, {tag, " no drive"}, 32'(oe_v), 32'd0);
    endtask

    task automatic wr_frame(input int npre, input logic [1:0] sfd, input logic [1:0] op,
                            input logic [1:0] ta, input logic [4:0] pa, input logic [4:0] ra,
                            input logic [15:0] val, input bit hit, input string tag);
        hdr(npre, sfd, op, pa, ra);
        tx(ta[1]); tx(ta[0]);
        for (int i = 15; i >= 0; i--) tx(val[i]);
        @(negedge mdc);
        chk(wr_stb == hit, {tag, " R9 strobe"}, 32'(wr_stb), 32'(hit));
        if (hit)
            chk({wr_reg, wr_val} == {ra, val}, {tag, " R9 strobe fields"},
                32'({wr_reg, wr_val}), 32'({ra, val}));
        @(posedge mdc);
        @(negedge mdc);
        chk(!wr_stb, {tag, " R9 strobe one cycle"}, 32'(wr_stb), 32'd0);
    endtask

    task automatic t_reset;
        @(negedge mdc);
        chk(!mdio_oe, "R1 oe after reset", 32'(mdio_oe), 32'd0);
        chk(!wr_stb, "R1 strobe after reset", 32'(wr_stb), 32'd0);
        rd_expect(32, 5'h0B, 5'd16, 16'h02C0, "R1 R10 strap field");
        rd_expect(32, 5'h0B, 5'd7, 16'h0000, "R1 zero register");
    endtask

    task automatic t_write_read;
        wr_frame(32, 2'b01, 2'b01, 2'b10, 5'h0B, 5'd3, 16'hA5C3, 1'b1, "R4 write");
        rd_expect(32, 5'h0B, 5'd3, 16'hA5C3, "R4 readback");
        wr_frame(32, 2'b01, 2'b01, 2'b10, 5'h0B, 5'd20, 16'hBEEF, 1'b1, "R5 write r20");
        rd_expect(32, 5'h0B, 5'd20, 16'hBEEF, "R5 reg 20");
        rd_expect(32, 5'h0B, 5'd5, 16'h0000, "R5 reg 5 untouched");
        wr_frame(32, 2'b01, 2'b01, 2'b11, 5'h0B, 5'd31, 16'hFFFF, 1'b1, "R9 turnaround 11");
        wr_frame(32, 2'b01, 2'b01, 2'b10, 5'h0B, 5'd0, 16'h0001, 1'b1, "R9 reg 0");
        rd_expect(40, 5'h0B, 5'd31, 16'hFFFF, "R8 all ones");
        rd_expect(32, 5'h0B, 5'd0, 16'h0001, "R8 lsb only");
    endtask

    task automatic t_preamble;
        wr_frame(31, 2'b01, 2'b01, 2'b10, 5'h0B, 5'd3, 16'h1111, 1'b0, "R2 31 ones write");
        rd_expect(32, 5'h0B, 5'd3, 16'hA5C3, "R2 unchanged");
        rd_none(31, 2'b01, 2'b10, 5'h0B, 5'd3, "R2 31 ones read");
        wr_frame(32, 2'b01, 2'b01, 2'b10, 5'h0B, 5'd3, 16'h2222, 1'b1, "R2 exactly 32");
        rd_expect(32, 5'h0B, 5'd3, 16'h2222, "R2 exact readback");
    endtask

    task automatic t_suppress;
        @(negedge mdc);
        pre_sup_en = 1'b1;
        rd_expect(32, 5'h0B, 5'd1, 16'h0040, "R3 status on");
        wr_frame(1, 2'b01, 2'b01, 2'b10, 5'h0B, 5'd9, 16'h5A5A, 1'b1, "R3 short write");
        rd_expect(1, 5'h0B, 5'd9, 16'h5A5A, "R3 short read");
        @(negedge mdc);
        pre_sup_en = 1'b0;
        rd_expect(32, 5'h0B, 5'd1, 16'h0000, "R3 status off");
        rd_none(1, 2'b01, 2'b10, 5'h0B, 5'd9, "R3 short refused");
    endtask

    task automatic t_bad_op;
        rd_none(32, 2'b01, 2'b11, 5'h0B, 5'd3, "R4 op 11");
        rd_none(32, 2'b01, 2'b00, 5'h0B, 5'd3, "R4 op 00");
        wr_frame(32, 2'b01, 2'b11, 2'b10, 5'h0B, 5'd3, 16'h3333, 1'b0, "R4 op 11 write");
        rd_expect(32, 5'h0B, 5'd3, 16'h2222, "R4 unchanged");
    endtask

    task automatic t_phy_miss;
        rd_none(32, 2'b01, 2'b10, 5'h0C, 5'd3, "R6 read miss");
        wr_frame(32, 2'b01, 2'b01, 2'b10, 5'h0C, 5'd3, 16'h4444, 1'b0, "R6 write miss");
        rd_expect(32, 5'h0B, 5'd3, 16'h2222, "R6 unchanged");
    endtask

    task automatic t_bad_sfd;
        wr_frame(32, 2'b00, 2'b01, 2'b10, 5'h0B, 5'd3, 16'h5555, 1'b0, "R12 start 00");
        rd_expect(32, 5'h0B, 5'd3, 16'h2222, "R12 unchanged");
    endtask

    task automatic t_read_only;
        wr_frame(32, 2'b01, 2'b01, 2'b10, 5'h0B, 5'd1, 16'hFFFF, 1'b1, "R11 write status");
        rd_expect(32, 5'h0B, 5'd1, 16'h0000, "R11 status kept");
    endtask

    task automatic t_addr_move;
        wr_frame(32, 2'b01, 2'b01, 2'b10, 5'h0B, 5'd16, 16'h04C0, 1'b1, "R10 new address");
        rd_none(32, 2'b01, 2'b10, 5'h0B, 5'd16, "R10 old address");
        rd_expect(32, 5'h13, 5'd16, 16'h04C0, "R10 answered at new");
        rd_expect(32, 5'h13, 5'd3, 16'h2222, "R10 data at new");
    endtask

    initial begin
        repeat (3) @(posedge mdc);
        @(negedge mdc);
        chk(!mdio_oe && !wr_stb, "R1 during reset", {30'd0, mdio_oe, wr_stb}, 32'd0);
        rst_n = 1'b1;
        t_reset();
        t_write_read();
        t_preamble();
        t_suppress();
        t_bad_op();
        t_phy_miss();
        t_bad_sfd();
        t_read_only();
        t_addr_move();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge mdc);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule